// File: doc/BRIEF.md
# Debug peripheral freeze controller

This block drives one freeze line per peripheral slot so that timers, watchdogs, the DMA engine, the USB core and the PWM LED driver can stop counting while a processor sits in a debug halt, or whenever software asks them to. Software keeps a per-slot freeze state through two word registers. Writing ones to the first register freezes the selected slots. Writing ones to the second register releases them. Reading either register returns the stored state.

Each of the two processors can also freeze every slot while it is halted in debug. A per-processor enable bit in a third register gates this. The system watchdog slot follows its own rules. A system processor halt always freezes it, whatever the enable says. A software freeze of that slot is suppressed while the watchdog runs in NMI-reset mode.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: After reset every stored freeze bit is 0 and every freeze output is 0. The debug enable register (word offset 8) reads 1: system enable in bit 0 is 1, radio enable in bit 1 is 0.
- R2: A write to offset 0 sets each stored bit whose write-data bit is 1. Data bits that are 0 leave their stored bits unchanged.
- R3: A write to offset 4 clears each stored bit whose write-data bit is 1. Data bits that are 0 leave their stored bits unchanged.
- R4: Reading offset 0 or offset 4 returns the stored freeze state in bits 10:0, with zeros above. Reading offset 8 returns the radio enable in bit 1 and the system enable in bit 0. Writes to offset 8 update both enables.
- R5: Stored bit i drives freeze_o[i]. Slot 0 is the wake-up timer, 1 SW timer, 2 reserved, 3 system watchdog, 4 USB, 5 DMA, 6 SW timer 2, 7 PWM LED, 8 SW timer 3, 9 SW timer 4, 10 radio watchdog. Bit 2 is stored and read back, but freeze_o[2] is always 0.
- R6: While sys_cpu_halted is 1 and the system enable is 1, every freeze output except bit 2 is 1.
- R7: While radio_cpu_halted is 1 and the radio enable is 1, every freeze output except bit 2 is 1. With the radio enable at 0, a radio halt has no effect on the outputs.
- R8: While sys_cpu_halted is 1, freeze_o[3] is 1 even when the system enable is 0.
- R9: Stored bit 3 drives freeze_o[3] only while wdog_nmi_mode is 0.
- R10: Halt-driven freezing never changes the stored state. A clear written during a halt is stored, and once the halt ends the outputs follow the stored state again.
- R11: A write to an unmapped or non-word-aligned address changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sys_cpu_halted | input | 1 | System processor is halted in debug |
| radio_cpu_halted | input | 1 | Radio processor is halted in debug |
| wdog_nmi_mode | input | 1 | System watchdog is configured for NMI-reset mode |
| freeze_o | output | 11 | Per-slot freeze outputs |

## Verification
A software write and a halt-driven freeze can act in the same cycle. The bench writes a clear while the system processor is halted and checks two things in that cycle: the outputs stay fully frozen, and the read-back already shows the cleared state. After the halt is released, it checks that the outputs fall back to the stored state. The same overlap arises between a system halt and a software watchdog freeze in NMI-reset mode. The bench checks that the halt still freezes the watchdog slot, and that the stored bit does not drive it once the halt ends.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int unsigned SLOT_COUNT = 11;
  localparam int unsigned SLOT_RSVD = 2;
  localparam int unsigned SLOT_SYS_WDOG = 3;

  typedef enum logic [1:0] {
    WIDX_SET = 2'd0,
    WIDX_CLR = 2'd1,
    WIDX_DBG = 2'd2,
    WIDX_NONE = 2'd3
  } widx_e;

  localparam logic [1:0] DBG_EN_RESET = 2'b01;
endpackage

// File: rtl/frz_sw_state.sv
module frz_sw_state #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] sw_q
);
  logic [N-1:0] sw_d;
  logic         sw_upd;

  always_comb begin
    sw_upd = (|set_mask) | (|clr_mask);
    sw_d   = (sw_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else if (sw_upd) begin
      sw_q <= sw_d;
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_mask) && ~|(set_mask & clr_mask)) |=> ((sw_q & $past(set_mask)) == $past(set_mask))); // R2

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((sw_q & $past(clr_mask)) == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (~|set_mask && ~|clr_mask) |=> $stable(sw_q)); // R10
endmodule

// File: rtl/frz_dbg_ctrl.sv
module frz_dbg_ctrl
  import frz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wbits,
  output logic       en_sys,
  output logic       en_radio
);
  logic [1:0] en_q;
  logic [1:0] en_d;

  always_comb begin
    en_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= DBG_EN_RESET;
    end else if (wr_stb) begin
      en_q <= en_d;
    end
  end

  assign en_sys   = en_q[0];
  assign en_radio = en_q[1];

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(en_q)); // R4
endmodule

// File: rtl/frz_combine.sv
module frz_combine
  import frz_pkg::*;
#(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sw_q,
  input  logic         en_sys,
  input  logic         en_radio,
  input  logic         sys_halted,
  input  logic         radio_halted,
  input  logic         wdog_nmi,
  output logic [N-1:0] freeze
);
  logic halt_all;

  assign halt_all = (sys_halted & en_sys) | (radio_halted & en_radio);

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == SLOT_RSVD) begin : g_rsvd
      assign freeze[i] = 1'b0;
    end else if (i == SLOT_SYS_WDOG) begin : g_wdog
      assign freeze[i] = (sw_q[i] & ~wdog_nmi) | sys_halted | halt_all;
    end else begin : g_plain
      assign freeze[i] = sw_q[i] | halt_all;
    end
  end

  AST_SYS_HALT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_halted && en_sys) |-> ($countones(freeze) == N - 1)); // R6

  AST_RADIO_HALT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_halted && en_radio) |-> ($countones(freeze) == N - 1)); // R7

  AST_WDOG_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    sys_halted |-> freeze[SLOT_SYS_WDOG]); // R8

  AST_NMI_BLOCKS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_nmi && !sys_halted && !(radio_halted && en_radio)) |-> !freeze[SLOT_SYS_WDOG]); // R9

  AST_NO_HALT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_halted && !(radio_halted && en_radio) && !wdog_nmi) |->
      (freeze == (sw_q & ~(N'(1) << SLOT_RSVD)))); // R10
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
  import frz_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SLOT_COUNT,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 sys_cpu_halted,
  input  logic                 radio_cpu_halted,
  input  logic                 wdog_nmi_mode,
  output logic [NUM_SLOTS-1:0] freeze_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  widx_e                widx;
  logic [NUM_SLOTS-1:0] set_mask;
  logic [NUM_SLOTS-1:0] clr_mask;
  logic                 dbg_wr;
  logic [NUM_SLOTS-1:0] sw_q;
  logic                 en_sys;
  logic                 en_radio;
  logic                 unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    widx = WIDX_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr[ADDR_W-1:2])
        IDX_W'(0): widx = WIDX_SET;
        IDX_W'(1): widx = WIDX_CLR;
        IDX_W'(2): widx = WIDX_DBG;
        default:   widx = WIDX_NONE;
      endcase
    end
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    dbg_wr   = 1'b0;
    if (bus_wr) begin
      case (widx)
        WIDX_SET: set_mask = bus_wdata[NUM_SLOTS-1:0];
        WIDX_CLR: clr_mask = bus_wdata[NUM_SLOTS-1:0];
        WIDX_DBG: dbg_wr   = 1'b1;
        default:  ;
      endcase
    end
  end

  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_SLOTS];

  always_comb begin
    bus_rdata = '0;
    case (widx)
      WIDX_SET, WIDX_CLR: bus_rdata[NUM_SLOTS-1:0] = sw_q;
      WIDX_DBG:           bus_rdata[1:0] = {en_radio, en_sys};
      default:            ;
    endcase
  end

  frz_sw_state #(.N(NUM_SLOTS)) i_sw_state (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .sw_q     (sw_q)
  );

  frz_dbg_ctrl i_dbg_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_stb   (dbg_wr),
    .wbits    (bus_wdata[1:0]),
    .en_sys   (en_sys),
    .en_radio (en_radio)
  );

  frz_combine #(.N(NUM_SLOTS)) i_combine (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sw_q         (sw_q),
    .en_sys       (en_sys),
    .en_radio     (en_radio),
    .sys_halted   (sys_cpu_halted),
    .radio_halted (radio_cpu_halted),
    .wdog_nmi     (wdog_nmi_mode),
    .freeze       (freeze_o)
  );

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !freeze_o[SLOT_RSVD]); // R5

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (widx == WIDX_NONE) |-> (bus_rdata == '0)); // R11
endmodule

// File: tb/test_dbg_freeze_ctrl.sv
module test_dbg_freeze_ctrl;
  localparam int N = 11;

  typedef struct {
    string       tag;
    logic [10:0] frz;
    logic [31:0] rd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_cpu_halted = 1'b0;
  logic        radio_cpu_halted = 1'b0;
  logic        wdog_nmi_mode = 1'b0;
  logic [10:0] freeze_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  logic [10:0] m_sw = '0;
  logic        m_es = 1'b1;
  logic        m_er = 1'b0;

  always #2 clk = ~clk;

  dbg_freeze_ctrl i_dbg_freeze_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_wr           (bus_wr),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .sys_cpu_halted   (sys_cpu_halted),
    .radio_cpu_halted (radio_cpu_halted),
    .wdog_nmi_mode    (wdog_nmi_mode),
    .freeze_o         (freeze_o)
  );

  function automatic logic [10:0] model_frz(logic sh, logic rh, logic nmi);
    logic [10:0] f;
    logic all;
    all = (sh & m_es) | (rh & m_er);
    f = m_sw;
    if (nmi) f[3] = 1'b0;
    if (all) f = 11'h7FF;
    if (sh) f[3] = 1'b1;
    f[2] = 1'b0;
    return f;
  endfunction

  function automatic logic [31:0] model_rd(logic [3:0] a);
    if (a == 4'd0 || a == 4'd4) return {21'd0, m_sw};
    if (a == 4'd8) return {30'd0, m_er, m_es};
    return 32'd0;
  endfunction

  task automatic step(input string tag, input logic wr, input logic [3:0] a,
                      input logic [31:0] wd, input logic sh, input logic rh, input logic nmi);
    exp_t e;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    sys_cpu_halted = sh; radio_cpu_halted = rh; wdog_nmi_mode = nmi;
    if (wr) begin
      if (a == 4'd0) m_sw = m_sw | wd[10:0];
      else if (a == 4'd4) m_sw = m_sw & ~wd[10:0];
      else if (a == 4'd8) begin m_es = wd[0]; m_er = wd[1]; end
    end
    e.tag = tag;
    e.frz = model_frz(sh, rh, nmi);
    e.rd  = model_rd(a);
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (freeze_o !== e.frz) begin
          errors++;
          $display("FAIL %s freeze_o actual %h expected %h", e.tag, freeze_o, e.frz);
        end
        checks++;
        if (bus_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s bus_rdata actual %h expected %h", e.tag, bus_rdata, e.rd);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step("R1 reset enables", 0, 4'd8, 0, 0, 0, 0);
    step("R1 reset state", 0, 4'd0, 0, 0, 0, 0);
    step("R2 R5 set pattern", 1, 4'd0, 32'h0A1, 0, 0, 0);
    step("R2 zero set no effect", 1, 4'd0, 32'h000, 0, 0, 0);
    step("R5 reserved stored not driven", 1, 4'd0, 32'h404, 0, 0, 0);
    step("R4 read via clear offset", 0, 4'd4, 0, 0, 0, 0);
    step("R3 clear pattern", 1, 4'd4, 32'h081, 0, 0, 0);
    step("R3 zero clear no effect", 1, 4'd4, 32'h000, 0, 0, 0);
    step("R9 wdog sw freeze nmi off", 1, 4'd0, 32'h008, 0, 0, 0);
    step("R9 wdog sw freeze nmi on", 0, 4'd0, 0, 0, 0, 1);
    step("R6 sys halt freezes all", 0, 4'd0, 0, 1, 0, 1);
    step("R10 clear during halt", 1, 4'd4, 32'h400, 1, 0, 1);
    step("R10 halt released", 0, 4'd0, 0, 0, 0, 1);
    step("R4 write enables off", 1, 4'd8, 32'h0, 0, 0, 1);
    step("R8 sys halt with enable off", 0, 4'd0, 0, 1, 0, 1);
    step("R7 radio halt disabled", 0, 4'd0, 0, 0, 1, 1);
    step("R7 radio halt enabled", 1, 4'd8, 32'h2, 0, 1, 1);
    step("R11 unmapped write", 1, 4'd12, 32'h300, 0, 0, 1);
    step("R11 misaligned write", 1, 4'd2, 32'h300, 0, 0, 1);
    step("R11 state unchanged", 0, 4'd0, 0, 0, 0, 1);
    step("R2 set all", 1, 4'd0, 32'h7FF, 0, 0, 0);
    step("R3 clear all", 1, 4'd4, 32'h7FF, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule